// File: doc/BRIEF.md
# Serial Transmitter with Frame-Safe Disable

This block is the transmit half of an asynchronous serial port. Characters written over a simple bus port go into a transmit buffer. A shift register takes them from the buffer and sends each one on a single line as a frame. A frame is one low start bit, then five to eight data bits sent least significant bit first, then one high stop bit. Every bit lasts a fixed number of cycles of an external oversampling tick, 16 by default. The buffer is either a multi-entry FIFO or a single holding register, chosen by a mode input.

The transmitter has two enables, a global one and a transmit one. Clearing either enable never cuts a frame short. The frame on the line runs to its stop bit, and after that no further character is taken from the buffer. The status word has a full flag and an empty flag. The empty flag describes the buffer only, so it can read empty while the last character is still being shifted out.

A test mode turns the buffer into a readable queue. In this mode a bus read of the data port pops the head entry, and nothing is sent on the line. The status word keeps its bit layout because software decodes it.

Top module: `sertx_core`

## Requirements
- R1: After reset the line `txd` is high and `status` equals 8'h80 (empty flag bit 7 set, full flag bit 5 clear, all other bits zero).
- R2: A frame is a low start bit, the data bits sent least significant bit first, then a high stop bit. Each bit holds for 16 cycles in which `tick16` is high. The line changes only in the cycle after a tick and stays high whenever no frame is in progress.
- R3: `wlen_sel` picks the data bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. The value is captured when a frame starts, and a change during the frame does not affect that frame.
- R4: With `fifo_mode`=1 the buffer holds up to DEPTH (16) characters and sends them in write order. Bit 5 is set exactly when DEPTH characters are held. A write while full is discarded.
- R5: With `fifo_mode`=0 the buffer is a single holding register. Bit 5 is set as soon as it holds one character, and further writes are discarded until it is emptied.
- R6: Bit 7 is set exactly when the buffer holds no character, whether or not a frame is still being shifted out.
- R7: A new frame starts only on a tick while `blk_en`=1, `tx_en`=1 and `test_mode`=0. Clearing either enable mid-frame lets that frame finish. Characters left in the buffer stay there until both enables are set again.
- R8: If a character is waiting when a stop bit ends, the next start bit begins on the tick that ends the stop bit, with no idle bit time in between.
- R9: With `test_mode`=1 nothing is sent. A cycle with `rd_en`=1 pops the head character, and `rd_data` shows the head character (0 when the buffer is empty). With `test_mode`=0, `rd_en` does not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe for the data port |
| wr_data | input | 8 | Character to enqueue |
| rd_en | input | 1 | Bus read strobe for the data port |
| rd_data | output | 8 | Head of the buffer (0 when empty) |
| test_mode | input | 1 | Makes the buffer readable and stops sending |
| blk_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| fifo_mode | input | 1 | 1: multi-entry FIFO, 0: single holding register |
| wlen_sel | input | 2 | Data bit count select |
| tick16 | input | 1 | Oversampling tick at 16 times the bit rate |
| txd | output | 1 | Serial line, idles high |
| status | output | 8 | Bit 5 full, bit 7 empty, other bits zero |

## Verification
Single characters are sent with each word-length code and with distinct bit patterns, so that bit order and the number of data bits can each be seen on the line. A sparse tick pattern and a tick on every cycle are both used, which shows that the bit time counts ticks and not clock cycles. Bursts are written with sending held off, which separates the depths of the FIFO and the holding register and exercises discarded writes. The bursts are then released back to back to show gapless framing. Enables are dropped in the middle of a frame, and test-mode reads pop the buffer without touching the line. A behavioural queue model in the bench is compared against `txd`, `status` and `rd_data` on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } tx_phase_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          one_entry,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   wp;
        logic [AW-1:0]   rp;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t        st_d, st_q;
    logic [DW-1:0]   mem_q [DEPTH];
    logic [CNTW-1:0] cap;
    logic            push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        cap     = one_entry ? CNTW'(1) : CNTW'(DEPTH);
        full    = (st_q.cnt >= cap);
        empty   = (st_q.cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem_q[st_q.rp];

        st_d = st_q;
        if (push_ok) st_d.wp = ptr_inc(st_q.wp);
        if (pop_ok)  st_d.rp = ptr_inc(st_q.rp);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CNTW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNTW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= push_data;
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go_ok,
    input  logic              have_data,
    input  logic [CHAR_W-1:0] data,
    input  logic [1:0]        wlen,
    output logic              load,
    output logic              txd
);
    localparam int TW = $clog2(OVS);

    typedef struct packed {
        tx_phase_e         phase;
        logic [TW-1:0]     tcnt;
        logic [2:0]        bidx;
        logic [2:0]        last;
        logic [CHAR_W-1:0] sh;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   bit_end;

    always_comb begin
        bit_end = tick && (st_q.tcnt == TW'(OVS - 1));
        load    = tick && go_ok && have_data &&
                  ((st_q.phase == PH_IDLE) || ((st_q.phase == PH_STOP) && bit_end));

        st_d = st_q;
        if (tick && st_q.phase != PH_IDLE)
            st_d.tcnt = bit_end ? '0 : st_q.tcnt + TW'(1);

        case (st_q.phase)
            PH_START: if (bit_end) begin
                st_d.phase = PH_DATA;
                st_d.bidx  = '0;
            end
            PH_DATA: if (bit_end) begin
                if (st_q.bidx == st_q.last) begin
                    st_d.phase = PH_STOP;
                end else begin
                    st_d.bidx = st_q.bidx + 3'd1;
                    st_d.sh   = st_q.sh >> 1;
                end
            end
            PH_STOP: if (bit_end) st_d.phase = PH_IDLE;
            default: ;
        endcase

        if (load) begin
            st_d.phase = PH_START;
            st_d.tcnt  = '0;
            st_d.bidx  = '0;
            st_d.sh    = data;
            st_d.last  = {1'b0, wlen} + 3'd4;
        end

        case (st_q.phase)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = st_q.sh[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    input  logic              test_mode,
    input  logic              blk_en,
    input  logic              tx_en,
    input  logic              fifo_mode,
    input  logic [1:0]        wlen_sel,
    input  logic              tick16,
    output logic              txd,
    output logic [7:0]        status
);
    localparam int FULL_BIT  = 5;
    localparam int EMPTY_BIT = 7;

    logic              buf_full, buf_empty;
    logic [CHAR_W-1:0] buf_head;
    logic              shift_load, test_pop, fifo_pop, go_ok;

    always_comb begin
        go_ok    = blk_en && tx_en && !test_mode;
        test_pop = test_mode && rd_en;
        fifo_pop = shift_load || test_pop;
        rd_data  = buf_empty ? '0 : buf_head;
        status            = '0;
        status[FULL_BIT]  = buf_full;
        status[EMPTY_BIT] = buf_empty;
    end

    sertx_fifo #(.DEPTH(DEPTH), .DW(CHAR_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .one_entry (!fifo_mode),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (fifo_pop),
        .head      (buf_head),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    sertx_shifter #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .go_ok     (go_ok),
        .have_data (!buf_empty),
        .data      (buf_head),
        .wlen      (wlen_sel),
        .load      (shift_load),
        .txd       (txd)
    );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       test_mode,
    input logic       blk_en,
    input logic       tx_en,
    input logic       fifo_mode,
    input logic       tick16,
    input logic       txd,
    input logic [7:0] status,
    input logic       shift_load,
    input logic       fifo_pop
);
    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(tick16));

    assert_full_drops_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && wr_en && !fifo_pop) |=> (status[5] || (fifo_mode != $past(fifo_mode))));

    assert_hold_reg_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && !status[7]) |-> status[5]);

    assert_start_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |-> (blk_en && tx_en && !test_mode && tick16 && !status[7]));

    assert_test_read_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && rd_en && status[5]) |=> (!status[5] || (fifo_mode != $past(fifo_mode))));
endmodule

bind sertx_core sertx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .test_mode  (test_mode),
    .blk_en     (blk_en),
    .tx_en      (tx_en),
    .fifo_mode  (fifo_mode),
    .tick16     (tick16),
    .txd        (txd),
    .status     (status),
    .shift_load (shift_load),
    .fifo_pop   (fifo_pop)
);

// File: tb/tb_sertx_core.sv
module tb_sertx_core;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       test_mode = 1'b0;
    logic       blk_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       fifo_mode = 1'b1;
    logic [1:0] wlen_sel = 2'b11;
    logic       tick16 = 1'b0;
    logic       txd;
    logic [7:0] status;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    int    tick_div = 1;
    int    tick_ctr = 0;
    bit    done = 0;

    // behavioural reference
    logic [7:0] q[$];
    int         m_ph = 0;
    int         m_cnt = 0;
    int         m_bit = 0;
    int         m_last = 0;
    logic [7:0] m_sh = '0;
    int         m_cap, m_n;
    bit         m_act, m_bend, m_ld, m_tpop, m_wok;
    logic [7:0] m_head;

    sertx_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .test_mode(test_mode),
        .blk_en(blk_en), .tx_en(tx_en), .fifo_mode(fifo_mode),
        .wlen_sel(wlen_sel), .tick16(tick16), .txd(txd), .status(status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick_ctr++;
            tick16 = ((tick_ctr % tick_div) == 0);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_ph = 0; m_cnt = 0; m_bit = 0; m_last = 0; m_sh = '0;
        end else begin
            m_cap  = fifo_mode ? DEPTH : 1;
            m_n    = q.size();
            m_act  = blk_en && tx_en && !test_mode;
            m_bend = tick16 && (m_cnt == 15);
            m_ld   = tick16 && m_act && (m_n > 0) && (m_ph == 0 || (m_ph == 3 && m_bend));
            m_tpop = test_mode && rd_en && (m_n > 0);
            m_wok  = wr_en && (m_n < m_cap);
            m_head = (m_n > 0) ? q[0] : 8'h00;
            if (m_ld || m_tpop) void'(q.pop_front());
            if (m_wok) q.push_back(wr_data);
            if (m_ld) begin
                m_ph = 1; m_cnt = 0; m_bit = 0; m_sh = m_head;
                m_last = int'(wlen_sel) + 4;
            end else if (tick16 && m_ph != 0) begin
                if (m_bend) begin
                    m_cnt = 0;
                    if (m_ph == 1) begin
                        m_ph = 2; m_bit = 0;
                    end else if (m_ph == 2) begin
                        if (m_bit == m_last) m_ph = 3;
                        else begin m_bit++; m_sh = m_sh >> 1; end
                    end else m_ph = 0;
                end else m_cnt++;
            end
        end
    end

    function automatic void check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit  exp_txd;
            logic [7:0] exp_st;
            exp_txd = (m_ph == 1) ? 1'b0 : (m_ph == 2) ? m_sh[0] : 1'b1;
            exp_st  = '0;
            exp_st[5] = (q.size() >= (fifo_mode ? DEPTH : 1));
            exp_st[7] = (q.size() == 0);
            check(txd === exp_txd, "txd", int'(txd), int'(exp_txd));
            check(status === exp_st, "status", int'(status), int'(exp_st));
            check(rd_data === ((q.size() > 0) ? q[0] : 8'h00), "rd_data",
                  int'(rd_data), (q.size() > 0) ? int'(q[0]) : 0);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic push(logic [7:0] b);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tread();
        @(posedge clk); #1;
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wait_idle(int limit);
        int k;
        for (k = 0; k < limit; k++) begin
            @(negedge clk);
            if (q.size() == 0 && m_ph == 0) break;
        end
        check(k < limit, "drain timeout", k, limit);
        cyc(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog %s: actual=hung expected=done", cur_req);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check(txd === 1'b1, "reset txd", int'(txd), 1);
        check(status === 8'h80, "reset status", int'(status), 8'h80);

        // frames with every word length, tick every cycle then sparse
        cur_req = "R2";
        blk_en = 1'b1; tx_en = 1'b1;
        push(8'hA5);
        wait_idle(400);
        cur_req = "R3";
        wlen_sel = 2'b00; push(8'h3B); wait_idle(400);
        wlen_sel = 2'b01; push(8'hC6); wait_idle(400);
        wlen_sel = 2'b10; push(8'h59); wait_idle(400);
        wlen_sel = 2'b11; push(8'h96);
        cyc(30); wlen_sel = 2'b00;
        wait_idle(400);
        cur_req = "R2";
        tick_div = 3; wlen_sel = 2'b11;
        push(8'h81); wait_idle(1200);
        tick_div = 1;

        // FIFO depth and dropped writes
        cur_req = "R4";
        tx_en = 1'b0;
        for (int i = 0; i < DEPTH + 3; i++) push(8'(i * 7 + 1));
        @(negedge clk);
        check(status === 8'h20, "fifo full", int'(status), 8'h20);
        cur_req = "R8";
        tick_div = 2; tx_en = 1'b1;
        cyc(800);
        cur_req = "R6";
        check(status[7] === 1'b0, "not yet empty", int'(status[7]), 0);
        cur_req = "R8";
        wait_idle(8000);
        tick_div = 1;

        // holding register mode
        cur_req = "R5";
        fifo_mode = 1'b0; tx_en = 1'b0;
        push(8'h12); push(8'h34);
        @(negedge clk);
        check(status === 8'h20, "holding full", int'(status), 8'h20);
        tx_en = 1'b1;
        cyc(20);
        cur_req = "R6";
        @(negedge clk);
        check(status === 8'h80, "empty while shifting", int'(status), 8'h80);
        check(txd === 1'b0 || txd === 1'b1, "line defined", int'(txd), 0);
        wait_idle(400);
        fifo_mode = 1'b1;

        // graceful disable
        cur_req = "R7";
        push(8'h6D); push(8'h2E);
        cyc(40); tx_en = 1'b0;
        cyc(300);
        @(negedge clk);
        check(status === 8'h00, "held after tx_en off", int'(status), 0);
        check(txd === 1'b1, "idle line tx_en off", int'(txd), 1);
        tx_en = 1'b1;
        cyc(40); blk_en = 1'b0;
        push(8'hF0);
        cyc(300);
        @(negedge clk);
        check(status === 8'h00, "held after blk_en off", int'(status), 0);
        check(txd === 1'b1, "idle line blk_en off", int'(txd), 1);
        blk_en = 1'b1;
        wait_idle(800);

        // test mode read path
        cur_req = "R9";
        test_mode = 1'b1;
        push(8'hAB); push(8'hCD); push(8'hEF);
        cyc(200);
        @(negedge clk);
        check(rd_data === 8'hAB, "head before pop", int'(rd_data), 8'hAB);
        check(txd === 1'b1, "no send in test", int'(txd), 1);
        tread();
        @(negedge clk);
        check(rd_data === 8'hCD, "head after pop", int'(rd_data), 8'hCD);
        tread(); tread();
        @(negedge clk);
        check(status === 8'h80, "emptied by reads", int'(status), 8'h80);
        test_mode = 1'b0; tx_en = 1'b0;
        push(8'h77);
        tread();
        @(negedge clk);
        check(rd_data === 8'h77, "read ignored outside test", int'(rd_data), 8'h77);
        tx_en = 1'b1;
        wait_idle(400);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule